// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether to keep it or drop it, using only the 48-bit destination address. The address is first compared against sixteen programmable station-address slots. A slot takes part only while its enable flag is set. If any enabled slot holds exactly the presented address, the frame is kept.

If no slot matches, the block falls back to an imperfect multicast filter. It takes a 12-bit hash from the top two address bytes and looks it up in a 4096-bit table. A set bit keeps the frame. A 2-bit window select decides which twelve bits of those two bytes form the hash.

Software programs the slots, the table and the window select through simple write ports. The parser drives the address with a one-cycle start strobe. One cycle later the block returns a verdict together with a valid pulse. A saturating counter records how many frames were kept through the hash path.

Top module: `rx_dest_filter`

## Requirements
- R1: There are 16 slots. Each slot is written as two 32-bit words, selected by `slot_wr_hi`. Low word: address byte 0 is in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. High word: byte 4 is in bits 7:0, byte 5 in 15:8, and the enable flag is bit 31. On `dest_addr`, byte n occupies bits 8n+7:8n.
- R2: A frame whose address equals an enabled slot is accepted. This does not change the counter, even if the hash bit for that address is also set.
- R3: Slots with the enable flag clear never cause acceptance. Rewriting a high word with bit 31 clear disables that slot.
- R4: The hash key is {byte 5, byte 4}. The key is shifted right by 4, 3, 2 or 0 places for window codes 0, 1, 2 and 3, and the low 12 bits of the result form the hash. The window code is written through `win_wr_en`/`win_wr_data`.
- R5: The table holds 128 words of 32 bits. Hash bits 11:5 pick the word and hash bits 4:0 pick the bit. When no slot matches, a set bit accepts the frame.
- R6: A frame that hits neither a slot nor a set table bit is rejected, and the counter is left unchanged.
- R7: Every acceptance through the table adds one to the counter. The counter is `CNT_W` bits wide, 32 by default, and stays at all-ones once it gets there.
- R8: `res_valid` is high for exactly one cycle, in the cycle after `start`. `res_accept` is meaningful in that cycle. The counter update becomes visible in that same cycle.
- R9: After reset, all slots are disabled, the table is all zero, the counter is zero, and every frame is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Address present, evaluate this cycle |
| dest_addr | input | 48 | Destination address, byte n in bits 8n+7:8n |
| slot_wr_en | input | 1 | Write one slot word |
| slot_wr_idx | input | 4 | Slot index |
| slot_wr_hi | input | 1 | 1 selects the high word, 0 the low word |
| slot_wr_data | input | 32 | Slot word data |
| tbl_wr_en | input | 1 | Write one hash table word |
| tbl_wr_idx | input | 7 | Table word index |
| tbl_wr_data | input | 32 | Table word data |
| win_wr_en | input | 1 | Write the hash window code |
| win_wr_data | input | 2 | Hash window code |
| res_valid | output | 1 | Verdict valid pulse |
| res_accept | output | 1 | 1 keeps the frame |
| mc_count | output | CNT_W | Saturating count of hash acceptances |

## Verification
The assertions assume that configuration writes never land in the same cycle as `start`. That rule lets the check "an exact match leaves the counter unchanged" treat the slot contents as fixed while the frame is evaluated. The stimulus always finishes a write and returns to idle before it raises `start`. It also leaves one idle cycle after every verdict, so the check that each valid pulse follows a start stays unambiguous. The bench narrows the counter width so that saturation can be reached in a few dozen frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned KEY_W  = 16;
  localparam int unsigned BIT_SEL_W = 5;

  // Right-shift applied to the hash key for each window code.
  function automatic logic [2:0] win_shift(input logic [1:0] code);
    case (code)
      2'd0:    win_shift = 3'd4;
      2'd1:    win_shift = 3'd3;
      2'd2:    win_shift = 3'd2;
      default: win_shift = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rxf_slot_bank.sv
module rxf_slot_bank #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic [47:0]       addr,
  output logic              hit
);
  logic [31:0] lo_q   [SLOTS];
  logic [15:0] hi_q   [SLOTS];
  logic        en_q   [SLOTS];
  logic [SLOTS-1:0] hit_vec;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic lo_we, hi_we;
    assign lo_we = wr_en && (wr_idx == IDX_W'(s)) && !wr_hi;
    assign hi_we = wr_en && (wr_idx == IDX_W'(s)) &&  wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[s] <= '0;
        hi_q[s] <= '0;
        en_q[s] <= 1'b0;
      end else begin
        if (lo_we) lo_q[s] <= wr_data;
        if (hi_we) begin
          hi_q[s] <= wr_data[15:0];
          en_q[s] <= wr_data[31];
        end
      end
    end

    assign hit_vec[s] = en_q[s] && ({hi_q[s], lo_q[s]} == addr);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
  import rxf_pkg::*;
#(
  parameter int unsigned WORDS = 128,
  localparam int unsigned WIDX_W = $clog2(WORDS),
  localparam int unsigned HASH_W = WIDX_W + BIT_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              win_wr_en,
  input  logic [1:0]        win_wr_data,
  input  logic [15:0]       key,
  output logic              hit
);
  logic [31:0] word_q [WORDS];
  logic [1:0]  win_q;
  logic [KEY_W-1:0]  shifted;
  logic [HASH_W-1:0] hash;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic we;
    assign we = wr_en && (wr_idx == WIDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q[w] <= '0;
      else if (we) word_q[w] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_q <= 2'd0;
    else if (win_wr_en) win_q <= win_wr_data;
  end

  always_comb begin
    shifted = key >> win_shift(win_q);
    hash    = shifted[HASH_W-1:0];
    hit     = word_q[hash[HASH_W-1:BIT_SEL_W]][hash[BIT_SEL_W-1:0]];
  end
endmodule

// File: rtl/rxf_sat_counter.sv
module rxf_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != {CNT_W{1'b1}});
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == {CNT_W{1'b1}}));

  assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned WORDS = 128,
  parameter int unsigned CNT_W = 32,
  localparam int unsigned SIDX_W = $clog2(SLOTS),
  localparam int unsigned WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [47:0]       dest_addr,
  input  logic              slot_wr_en,
  input  logic [SIDX_W-1:0] slot_wr_idx,
  input  logic              slot_wr_hi,
  input  logic [31:0]       slot_wr_data,
  input  logic              tbl_wr_en,
  input  logic [WIDX_W-1:0] tbl_wr_idx,
  input  logic [31:0]       tbl_wr_data,
  input  logic              win_wr_en,
  input  logic [1:0]        win_wr_data,
  output logic              res_valid,
  output logic              res_accept,
  output logic [CNT_W-1:0]  mc_count
);
  logic exact_hit, hash_hit;
  logic accept_d, hash_take;
  logic valid_q, accept_q;

  rxf_slot_bank #(.SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_wr_en), .wr_idx(slot_wr_idx), .wr_hi(slot_wr_hi),
    .wr_data(slot_wr_data), .addr(dest_addr), .hit(exact_hit)
  );

  rxf_hash_table #(.WORDS(WORDS)) u_hash (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data),
    .key(dest_addr[47:32]), .hit(hash_hit)
  );

  always_comb begin
    hash_take = start && !exact_hit && hash_hit;
    accept_d  = exact_hit || hash_hit;
  end

  rxf_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(hash_take), .count(mc_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) accept_q <= accept_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = accept_q;

  assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(start));

  assert_exact_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && exact_hit) |=> $stable(mc_count));

  assert_reject_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_accept) |-> $stable(mc_count));

  assert_idle_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(mc_count));
endmodule

// File: tb/rx_dest_filter_tb.sv
module rx_dest_filter_tb;
  localparam int CNT_W = 4;
  localparam int NVEC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [47:0] dest_addr = '0;
  logic slot_wr_en = 1'b0, slot_wr_hi = 1'b0;
  logic [3:0] slot_wr_idx = '0;
  logic [31:0] slot_wr_data = '0;
  logic tbl_wr_en = 1'b0;
  logic [6:0] tbl_wr_idx = '0;
  logic [31:0] tbl_wr_data = '0;
  logic win_wr_en = 1'b0;
  logic [1:0] win_wr_data = '0;
  logic res_valid, res_accept;
  logic [CNT_W-1:0] mc_count;

  int errors = 0, checks = 0;
  logic [31:0] shadow [128];
  int exp_cnt = 0;

  always #2 clk = ~clk;

  rx_dest_filter #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dest_addr(dest_addr),
    .slot_wr_en(slot_wr_en), .slot_wr_idx(slot_wr_idx), .slot_wr_hi(slot_wr_hi),
    .slot_wr_data(slot_wr_data), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
    .tbl_wr_data(tbl_wr_data), .win_wr_en(win_wr_en), .win_wr_data(win_wr_data),
    .res_valid(res_valid), .res_accept(res_accept), .mc_count(mc_count)
  );

  localparam logic [47:0] A_ADDR = 48'h5544_3322_1100;
  localparam logic [47:0] B_ADDR = 48'h0B0A_0908_0706;
  localparam logic [47:0] C_ADDR = 48'hFFEE_DDCC_BBAA;
  localparam logic [47:0] M1 = 48'h1234_0000_0001;
  localparam logic [47:0] M2 = 48'h0ABC_0000_0002;
  localparam logic [47:0] M4 = 48'h1F0F_0000_0003;
  localparam logic [47:0] M5 = 48'hFFFF_0000_0004;
  localparam logic [47:0] M6 = 48'h0000_0000_0005;

  // {address, window code, expected accept, expected counter step}
  localparam logic [51:0] VEC [NVEC] = '{
    {A_ADDR, 2'd0, 1'b1, 1'b0},  // R2 exact match, hash bit also set
    {C_ADDR, 2'd2, 1'b1, 1'b0},  // R2
    {B_ADDR, 2'd0, 1'b0, 1'b0},  // R3 disabled slot
    {M1,     2'd0, 1'b1, 1'b1},  // R4 shift 4
    {M1,     2'd1, 1'b0, 1'b0},  // R6
    {M2,     2'd3, 1'b1, 1'b1},  // R4 shift 0
    {M2,     2'd0, 1'b0, 1'b0},  // R6
    {M4,     2'd1, 1'b1, 1'b1},  // R4 shift 3
    {M4,     2'd2, 1'b0, 1'b0},  // R4 shift 2, unset bit
    {M5,     2'd3, 1'b1, 1'b1}   // R5 last word, last bit
  };

  function automatic logic [11:0] ref_hash(input logic [47:0] a, input logic [1:0] w);
    logic [15:0] k;
    int sh;
    k = a[47:32];
    sh = (w == 2'd0) ? 4 : (w == 2'd1) ? 3 : (w == 2'd2) ? 2 : 0;
    return 12'(k >> sh);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_slot(input int idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    slot_wr_en = 1'b1; slot_wr_idx = 4'(idx); slot_wr_hi = hi; slot_wr_data = d;
    @(negedge clk);
    slot_wr_en = 1'b0;
  endtask

  task automatic set_hash_bit(input logic [11:0] h);
    shadow[h[11:5]][h[4:0]] = 1'b1;
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = h[11:5]; tbl_wr_data = shadow[h[11:5]];
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic wr_win(input logic [1:0] w);
    @(negedge clk);
    win_wr_en = 1'b1; win_wr_data = w;
    @(negedge clk);
    win_wr_en = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input logic [1:0] w,
                       input bit exp_acc, input bit step, input string req);
    int nxt;
    wr_win(w);
    @(negedge clk);
    start = 1'b1; dest_addr = a;
    @(negedge clk);
    start = 1'b0;
    nxt = exp_cnt + (step ? 1 : 0);
    if (nxt > (1 << CNT_W) - 1) nxt = (1 << CNT_W) - 1;
    exp_cnt = nxt;
    check(res_valid === 1'b1, "R8", "valid pulse", int'(res_valid), 1);
    check(res_accept === exp_acc, req, "accept", int'(res_accept), int'(exp_acc));
    check(int'(mc_count) == exp_cnt, (step ? "R7" : "R6"), "counter",
          int'(mc_count), exp_cnt);
    @(negedge clk);
    check(res_valid === 1'b0, "R8", "valid single cycle", int'(res_valid), 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(res_valid === 1'b0, "R9", "valid after reset", int'(res_valid), 0);
    check(mc_count === '0, "R9", "counter after reset", int'(mc_count), 0);
    frame(A_ADDR, 2'd0, 1'b0, 1'b0, "R9");
    frame(M6, 2'd0, 1'b0, 1'b0, "R9");

    // Program slots (R1)
    wr_slot(0, 1'b0, A_ADDR[31:0]);
    wr_slot(0, 1'b1, {1'b1, 15'd0, A_ADDR[47:32]});
    wr_slot(5, 1'b0, B_ADDR[31:0]);
    wr_slot(5, 1'b1, {1'b0, 15'd0, B_ADDR[47:32]});
    wr_slot(15, 1'b0, C_ADDR[31:0]);
    wr_slot(15, 1'b1, {1'b1, 15'd0, C_ADDR[47:32]});

    // Program hash bits (R5)
    set_hash_bit(ref_hash(M1, 2'd0));
    set_hash_bit(ref_hash(A_ADDR, 2'd0));
    set_hash_bit(ref_hash(M2, 2'd3));
    set_hash_bit(ref_hash(M4, 2'd1));
    set_hash_bit(ref_hash(M5, 2'd3));
    set_hash_bit(ref_hash(M6, 2'd0));

    for (int v = 0; v < NVEC; v++) begin
      frame(VEC[v][51:4], VEC[v][3:2], VEC[v][1], VEC[v][0], "R1");
    end

    // R5 first word, bit 0
    frame(M6, 2'd0, 1'b1, 1'b1, "R5");
    // R3 disable slot 0 by rewriting its high word: A falls to hash
    wr_slot(0, 1'b1, {1'b0, 15'd0, A_ADDR[47:32]});
    frame(A_ADDR, 2'd0, 1'b1, 1'b1, "R3");
    // R7 saturation
    for (int k = 0; k < 12; k++) frame(M1, 2'd0, 1'b1, 1'b1, "R7");
    check(int'(mc_count) == 15, "R7", "saturated counter", int'(mc_count), 15);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule